// File: doc/BRIEF.md
# PCIe Configuration Request Router

This block sits between the configuration-access engine of a root port and the two places where configuration registers live. Each request names a bus, device and function, a byte offset, an access size of 1, 2 or 4 bytes and, for writes, the data. The router works out whether the request addresses the root port's own register file, a device on the bus directly below the root port, a device behind further bridges, or nothing that can exist. It then issues one dword-aligned access on the matching backend port and handles the sub-word byte lanes itself.

Two backends are served. The local port reaches the root port's own registers. The translated port carries requests toward the link and is tagged with the header type to use: type 0 for the bus directly below the root, type 1 beyond it. The caller supplies the root bus number, the upstream (parent) bus number of the target bus and a link-up flag. Requests are handled one at a time. A completion pulse returns a status code with the read data.

Top module: `cfg_router`

## Requirements
- R1: A request whose bus equals `root_bus` is issued on the local port. Any other accepted request is issued on the translated port. The two ports never request at the same time.
- R2: A request whose bus differs from `root_bus` while `link_up` is 0 completes with status 1 (no device) and makes no backend access. A root-bus request still proceeds while the link is down.
- R3: On the root bus, and on a bus whose parent equals `root_bus`, any device number other than 0 completes with status 1 and makes no backend access. On deeper buses every device number is accepted.
- R4: Any request that completes with a non-zero status returns `rsp_rdata` = 0xFFFFFFFF. A rejected write reaches neither backend.
- R5: A translated request uses type 0 (`xc_type1` = 0) when `req_parent` equals `root_bus`, and type 1 otherwise. Bus, device and function pass through unchanged.
- R6: The backend address is `req_offset` with its two low bits forced to zero.
- R7: Reads fetch the whole dword (byte enables 4'b1111). For size 1 the result is the dword shifted right by 8 × offset[1:0] and masked to 8 bits. For size 2 it is shifted by the same amount and masked to 16 bits. For size 4 it is the dword unchanged.
- R8: Writes drive byte enables instead of a read-modify-write. For size 1 the enable is 4'b0001 shifted left by offset[1:0]. For size 2 it is 4'b0011 shifted left by (offset & 2). For size 4 it is 4'b1111. The low 8 or 16 bits of `req_wdata` are moved onto the enabled lanes, and the disabled lanes carry zero. A successful write returns `rsp_rdata` = 0.
- R9: A size other than 1, 2 or 4 completes with status 2 (bad register) and makes no backend access. When the target is also rejected, status 1 wins.
- R10: Only one request is in flight. `req_ready` falls on acceptance and rises again in the cycle after the single-cycle `rsp_valid` pulse. A backend request stays asserted with stable fields until its acknowledge.
- R11: After reset `req_ready` is 1, and `rsp_valid`, `loc_req` and `xc_req` are 0. A successful completion has status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_bus | input | 8 | Bus number of the root port |
| link_up | input | 1 | Link to the downstream device is trained |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Router can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_parent | input | 8 | Parent (upstream) bus number of the target bus |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_offset | input | 12 | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Completion pulse |
| rsp_status | output | 2 | 0 ok, 1 no device, 2 bad register |
| rsp_rdata | output | 32 | Read result, right-aligned |
| loc_req | output | 1 | Local register access request |
| loc_write | output | 1 | Local access is a write |
| loc_addr | output | 12 | Local dword-aligned address |
| loc_be | output | 4 | Local byte enables |
| loc_wdata | output | 32 | Local lane-placed write data |
| loc_ack | input | 1 | Local access complete |
| loc_rdata | input | 32 | Local read dword, valid with ack |
| xc_req | output | 1 | Translated access request |
| xc_write | output | 1 | Translated access is a write |
| xc_type1 | output | 1 | 1 = type 1 header, 0 = type 0 |
| xc_bus | output | 8 | Translated target bus |
| xc_dev | output | 5 | Translated target device |
| xc_func | output | 3 | Translated target function |
| xc_addr | output | 12 | Translated dword-aligned address |
| xc_be | output | 4 | Translated byte enables |
| xc_wdata | output | 32 | Translated lane-placed write data |
| xc_ack | input | 1 | Translated access complete |
| xc_rdata | input | 32 | Translated read dword, valid with ack |

## Verification
The properties assume that each backend raises its acknowledge only while its own request is asserted, and for a single cycle. They also assume that request fields matter only in the cycle `req_valid` meets `req_ready`. The bench's backend model acknowledges only after it has seen a request, with a latency of zero to several cycles. It returns a dword derived from the address, so every byte lane is distinct. The driver holds `req_valid` for exactly one accepted cycle and waits for `req_ready` before offering the next request, so no request is ever offered while another is in flight.

// File: rtl/cfg_router_pkg.sv
`timescale 1ns/1ps
package cfg_router_pkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_NODEV  = 2'd1,
    ST_BADREG = 2'd2
  } cfg_status_e;

  typedef enum logic [1:0] {
    TGT_LOCAL = 2'd0,
    TGT_TYPE0 = 2'd1,
    TGT_TYPE1 = 2'd2,
    TGT_NONE  = 2'd3
  } cfg_target_e;
endpackage

// File: rtl/cfg_router_decode.sv
`timescale 1ns/1ps
module cfg_router_decode
  import cfg_router_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic [BUS_W-1:0]  root_bus,
  input  logic              link_up,
  input  logic [BUS_W-1:0]  bus,
  input  logic [BUS_W-1:0]  parent,
  input  logic [DEV_W-1:0]  dev,
  input  logic [SIZE_W-1:0] size,
  output cfg_target_e       target,
  output cfg_status_e       status
);
  logic on_root, below_root, dev_zero, size_ok;

  assign on_root    = (bus == root_bus);
  assign below_root = (parent == root_bus);
  assign dev_zero   = (dev == '0);
  assign size_ok    = (size == SIZE_W'(1)) || (size == SIZE_W'(2)) ||
                      (size == SIZE_W'(LANES));

  always_comb begin
    if (on_root)          target = dev_zero ? TGT_LOCAL : TGT_NONE;
    else if (!link_up)    target = TGT_NONE;
    else if (below_root)  target = dev_zero ? TGT_TYPE0 : TGT_NONE;
    else                  target = TGT_TYPE1;

    if (target == TGT_NONE) status = ST_NODEV;
    else if (!size_ok)      status = ST_BADREG;
    else                    status = ST_OK;
  end
endmodule

// File: rtl/cfg_router_lane_pack.sv
`timescale 1ns/1ps
module cfg_router_lane_pack #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [LANE_W-1:0] ofs_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata_lane
);
  logic [LANE_W-1:0] lane;
  logic [LANES-1:0]  be_base;
  logic [DATA_W-1:0] mask;

  always_comb begin
    case (size)
      SIZE_W'(1): begin
        lane    = ofs_lo;
        be_base = LANES'(1);
        mask    = DATA_W'(8'hFF);
      end
      SIZE_W'(2): begin
        lane    = {ofs_lo[LANE_W-1:1], 1'b0};
        be_base = LANES'(3);
        mask    = DATA_W'(16'hFFFF);
      end
      default: begin
        lane    = '0;
        be_base = '1;
        mask    = '1;
      end
    endcase
    be         = be_base << lane;
    wdata_lane = (wdata & mask) << {lane, 3'b000};
  end
endmodule

// File: rtl/cfg_router_lane_extract.sv
`timescale 1ns/1ps
module cfg_router_lane_extract #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [LANE_W-1:0] ofs_lo,
  input  logic [DATA_W-1:0] dword,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = dword >> {ofs_lo, 3'b000};
    case (size)
      SIZE_W'(1): result = shifted & DATA_W'(8'hFF);
      SIZE_W'(2): result = shifted & DATA_W'(16'hFFFF);
      default:    result = dword;
    endcase
  end
endmodule

// File: rtl/cfg_router.sv
`timescale 1ns/1ps
module cfg_router
  import cfg_router_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FUNC_W = 3,
  parameter int OFS_W  = 12,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  root_bus,
  input  logic              link_up,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [BUS_W-1:0]  req_parent,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              loc_req,
  output logic              loc_write,
  output logic [OFS_W-1:0]  loc_addr,
  output logic [LANES-1:0]  loc_be,
  output logic [DATA_W-1:0] loc_wdata,
  input  logic              loc_ack,
  input  logic [DATA_W-1:0] loc_rdata,
  output logic              xc_req,
  output logic              xc_write,
  output logic              xc_type1,
  output logic [BUS_W-1:0]  xc_bus,
  output logic [DEV_W-1:0]  xc_dev,
  output logic [FUNC_W-1:0] xc_func,
  output logic [OFS_W-1:0]  xc_addr,
  output logic [LANES-1:0]  xc_be,
  output logic [DATA_W-1:0] xc_wdata,
  input  logic              xc_ack,
  input  logic [DATA_W-1:0] xc_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} fsm_e;

  fsm_e              state;
  cfg_target_e       dec_target;
  cfg_status_e       dec_status;
  logic [LANES-1:0]  pk_be;
  logic [DATA_W-1:0] pk_wdata;
  logic [LANES-1:0]  issue_be;
  logic [DATA_W-1:0] issue_wdata;
  logic [OFS_W-1:0]  issue_addr;
  logic [SIZE_W-1:0] size_q;
  logic [LANE_W-1:0] ofs_lo_q;
  logic              write_q;
  logic [DATA_W-1:0] back_dword;
  logic [DATA_W-1:0] rd_result;
  logic              back_done;

  cfg_router_decode #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)
  ) decode_i (
    .root_bus(root_bus), .link_up(link_up), .bus(req_bus), .parent(req_parent),
    .dev(req_dev), .size(req_size), .target(dec_target), .status(dec_status)
  );

  cfg_router_lane_pack #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) pack_i (
    .size(req_size), .ofs_lo(req_offset[LANE_W-1:0]), .wdata(req_wdata),
    .be(pk_be), .wdata_lane(pk_wdata)
  );

  cfg_router_lane_extract #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) extract_i (
    .size(size_q), .ofs_lo(ofs_lo_q), .dword(back_dword), .result(rd_result)
  );

  // reads fetch the whole dword; lane selection happens on the way back
  assign issue_be    = req_write ? pk_be : '1;
  assign issue_wdata = req_write ? pk_wdata : '0;
  assign issue_addr  = {req_offset[OFS_W-1:LANE_W], {LANE_W{1'b0}}};
  assign back_dword  = loc_req ? loc_rdata : xc_rdata;
  assign back_done   = (loc_req && loc_ack) || (xc_req && xc_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_rdata  <= '0;
      size_q     <= '0;
      ofs_lo_q   <= '0;
      write_q    <= 1'b0;
      loc_req    <= 1'b0;
      loc_write  <= 1'b0;
      loc_addr   <= '0;
      loc_be     <= '0;
      loc_wdata  <= '0;
      xc_req     <= 1'b0;
      xc_write   <= 1'b0;
      xc_type1   <= 1'b0;
      xc_bus     <= '0;
      xc_dev     <= '0;
      xc_func    <= '0;
      xc_addr    <= '0;
      xc_be      <= '0;
      xc_wdata   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            req_ready <= 1'b0;
            size_q    <= req_size;
            ofs_lo_q  <= req_offset[LANE_W-1:0];
            write_q   <= req_write;
            if (dec_status != ST_OK) begin
              rsp_valid  <= 1'b1;
              rsp_status <= dec_status;
              rsp_rdata  <= '1;
              state      <= S_DONE;
            end else if (dec_target == TGT_LOCAL) begin
              loc_req   <= 1'b1;
              loc_write <= req_write;
              loc_addr  <= issue_addr;
              loc_be    <= issue_be;
              loc_wdata <= issue_wdata;
              state     <= S_WAIT;
            end else begin
              xc_req   <= 1'b1;
              xc_write <= req_write;
              xc_type1 <= (dec_target == TGT_TYPE1);
              xc_bus   <= req_bus;
              xc_dev   <= req_dev;
              xc_func  <= req_func;
              xc_addr  <= issue_addr;
              xc_be    <= issue_be;
              xc_wdata <= issue_wdata;
              state    <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (back_done) begin
            loc_req    <= 1'b0;
            xc_req     <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_rdata  <= write_q ? '0 : rd_result;
            state      <= S_DONE;
          end
        end
        default: begin
          rsp_valid <= 1'b0;
          req_ready <= 1'b1;
          state     <= S_IDLE;
        end
      endcase
    end
  end

  assert_one_port_R1: assert property (@(posedge clk) disable iff (rst)
    !(loc_req && xc_req));

  assert_loc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (loc_req && !loc_ack) |=> (loc_req && $stable(loc_addr) && $stable(loc_be)
                               && $stable(loc_wdata)));

  assert_xc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (xc_req && !xc_ack) |=> (xc_req && $stable(xc_addr) && $stable(xc_be)
                             && $stable(xc_bus) && $stable(xc_type1)));

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !(loc_req || xc_req || rsp_valid));

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_reject_ones_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != ST_OK) |-> (rsp_rdata == '1));

  assert_type0_dev_R3: assert property (@(posedge clk) disable iff (rst)
    (xc_req && !xc_type1) |-> (xc_dev == '0));

  assert_be_shape_R8: assert property (@(posedge clk) disable iff (rst)
    loc_req |-> ($countones(loc_be) == 1 || $countones(loc_be) == 2 ||
                 $countones(loc_be) == LANES));
endmodule

// File: tb/cfg_router_tb_top.sv
`timescale 1ns/1ps
module cfg_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  root_bus = 8'h02;
  logic        link_up = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_parent = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [11:0] req_offset = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;
  logic        loc_req, loc_write, loc_ack;
  logic [11:0] loc_addr;
  logic [3:0]  loc_be;
  logic [31:0] loc_wdata, loc_rdata;
  logic        xc_req, xc_write, xc_type1, xc_ack;
  logic [7:0]  xc_bus;
  logic [4:0]  xc_dev;
  logic [2:0]  xc_func;
  logic [11:0] xc_addr;
  logic [3:0]  xc_be;
  logic [31:0] xc_wdata, xc_rdata;

  always #2.5 clk = ~clk;

  cfg_router dut_i (
    .clk(clk), .rst(rst), .root_bus(root_bus), .link_up(link_up),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_parent(req_parent), .req_dev(req_dev),
    .req_func(req_func), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .loc_req(loc_req), .loc_write(loc_write),
    .loc_addr(loc_addr), .loc_be(loc_be), .loc_wdata(loc_wdata),
    .loc_ack(loc_ack), .loc_rdata(loc_rdata), .xc_req(xc_req),
    .xc_write(xc_write), .xc_type1(xc_type1), .xc_bus(xc_bus),
    .xc_dev(xc_dev), .xc_func(xc_func), .xc_addr(xc_addr), .xc_be(xc_be),
    .xc_wdata(xc_wdata), .xc_ack(xc_ack), .xc_rdata(xc_rdata)
  );

  typedef struct {
    bit          xc;
    bit          wr;
    bit          t1;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    string       tag;
  } back_exp_t;

  typedef struct {
    logic [1:0]  st;
    logic [31:0] rd;
    string       tag;
  } rsp_exp_t;

  back_exp_t back_q[$];
  rsp_exp_t  rsp_q[$];
  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  bit done   = 1'b0;

  function automatic logic [31:0] loc_word(logic [11:0] a);
    return 32'h44332211 + {20'h0, a};
  endfunction

  function automatic logic [31:0] xc_word(logic [7:0] b, logic [11:0] a);
    return 32'hC0B0A090 ^ {b, 12'h000, a};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: computes expectations from the requirements and offers one request
  task automatic send(bit wr, logic [7:0] bus, logic [7:0] par, logic [4:0] dev,
                      logic [2:0] fn, logic [11:0] ofs, logic [2:0] sz,
                      logic [31:0] wd, string tag);
    bit reject, bad, t1, xc;
    logic [1:0]  lane;
    logic [3:0]  be;
    logic [31:0] mask, word, sh;
    back_exp_t b;
    rsp_exp_t r;
    xc = (bus != root_bus);
    reject = (!xc && dev != 0) || (xc && !link_up) || (xc && par == root_bus && dev != 0);
    bad = !(sz == 1 || sz == 2 || sz == 4);
    t1 = (par != root_bus);
    r.tag = tag;
    if (reject || bad) begin
      r.st = reject ? 2'd1 : 2'd2;
      r.rd = 32'hFFFFFFFF;
    end else begin
      r.st = 2'd0;
      lane = (sz == 1) ? ofs[1:0] : (sz == 2) ? {ofs[1], 1'b0} : 2'd0;
      be   = (sz == 1) ? (4'b0001 << lane) : (sz == 2) ? (4'b0011 << lane) : 4'b1111;
      mask = (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFFFFFF;
      b.xc = xc; b.wr = wr; b.t1 = t1; b.bus = bus; b.dev = dev; b.fn = fn;
      b.addr = {ofs[11:2], 2'b00}; b.tag = tag;
      b.be = wr ? be : 4'b1111;
      b.wd = wr ? ((wd & mask) << (8 * lane)) : 32'h0;
      back_q.push_back(b);
      word = xc ? xc_word(bus, b.addr) : loc_word(b.addr);
      sh = word >> (8 * ofs[1:0]);
      r.rd = wr ? 32'h0 : ((sz == 4) ? word : (sh & mask));
    end
    rsp_q.push_back(r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_write = wr; req_bus = bus; req_parent = par; req_dev = dev;
    req_func = fn; req_offset = ofs; req_size = sz; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10", "ready low after accept", req_ready, 0);
  endtask

  // backend model: checks each issued access, then acknowledges after lat cycles
  initial begin
    bit busy;
    int cnt;
    busy = 0; cnt = 0;
    loc_ack = 0; xc_ack = 0; loc_rdata = '0; xc_rdata = '0;
    forever begin
      @(negedge clk);
      loc_ack = 0; xc_ack = 0;
      if (!rst && (loc_req || xc_req) && !busy) begin
        busy = 1; cnt = lat;
        if (back_q.size() == 0) begin
          check(0, "R4", "unexpected backend access", {loc_req, xc_req}, 0);
        end else begin
          back_exp_t e;
          bit ok;
          e = back_q.pop_front();
          if (e.xc)
            ok = xc_req && !loc_req && xc_write == e.wr && xc_type1 == e.t1 &&
                 xc_bus == e.bus && xc_dev == e.dev && xc_func == e.fn &&
                 xc_addr == e.addr && xc_be == e.be && xc_wdata == e.wd;
          else
            ok = loc_req && !xc_req && loc_write == e.wr && loc_addr == e.addr &&
                 loc_be == e.be && loc_wdata == e.wd;
          check(ok, e.tag, "backend access",
                e.xc ? {xc_type1, xc_bus, xc_dev, xc_addr, xc_be, xc_wdata[15:0]}
                     : {loc_write, loc_addr, loc_be, loc_wdata},
                e.xc ? {e.t1, e.bus, e.dev, e.addr, e.be, e.wd[15:0]}
                     : {e.wr, e.addr, e.be, e.wd});
        end
      end else if (busy && cnt > 0) begin
        cnt--;
      end
      if (busy && cnt == 0) begin
        busy = 0;
        if (loc_req) begin loc_rdata = loc_word(loc_addr); loc_ack = 1; end
        if (xc_req)  begin xc_rdata = xc_word(xc_bus, xc_addr); xc_ack = 1; end
      end
    end
  end

  // response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (rsp_q.size() == 0) begin
          check(0, "R10", "unexpected completion", rsp_status, 0);
        end else begin
          rsp_exp_t e;
          e = rsp_q.pop_front();
          check(rsp_status == e.st && rsp_rdata == e.rd, e.tag, "completion",
                {rsp_status, rsp_rdata}, {e.st, e.rd});
          check(!req_ready, "R10", "ready low during completion", req_ready, 0);
        end
      end
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !loc_req && !xc_req, "R11", "reset state",
          {req_ready, rsp_valid, loc_req, xc_req}, 4'b1000);

    lat = 0;
    send(0, 8'h02, 8'h00, 5'd0, 3'd0, 12'h010, 3'd4, 32'h0, "R1 R7 R11 local dword read");
    send(0, 8'h02, 8'h00, 5'd0, 3'd0, 12'h013, 3'd1, 32'h0, "R7 byte read lane 3");
    lat = 2;
    send(0, 8'h02, 8'h00, 5'd0, 3'd0, 12'h016, 3'd2, 32'h0, "R7 half read lane 2");
    send(0, 8'h02, 8'h00, 5'd0, 3'd0, 12'h003, 3'd2, 32'h0, "R7 half read odd offset");
    send(1, 8'h02, 8'h00, 5'd0, 3'd0, 12'h021, 3'd1, 32'hABCDEF5A, "R8 byte write lane 1");
    lat = 1;
    send(1, 8'h02, 8'h00, 5'd0, 3'd0, 12'h033, 3'd2, 32'h1234BEEF, "R8 half write offset 3");
    send(1, 8'h02, 8'h00, 5'd0, 3'd0, 12'h040, 3'd4, 32'hCAFEF00D, "R8 dword write");
    lat = 3;
    send(0, 8'h03, 8'h02, 5'd0, 3'd5, 12'h100, 3'd4, 32'h0, "R5 R1 type0 read");
    send(1, 8'h05, 8'h03, 5'd7, 3'd2, 12'h0FE, 3'd2, 32'h00005566, "R5 R3 type1 write any device");
    send(0, 8'h09, 8'h04, 5'd1, 3'd1, 12'hFFF, 3'd1, 32'h0, "R6 R7 top offset byte read");
    lat = 0;
    send(0, 8'h02, 8'h00, 5'd1, 3'd0, 12'h000, 3'd4, 32'h0, "R3 R4 root bus device 1 read");
    send(1, 8'h03, 8'h02, 5'd4, 3'd0, 12'h010, 3'd4, 32'h11111111, "R3 R4 below-root device 4 write");
    link_up = 1'b0;
    send(0, 8'h05, 8'h03, 5'd0, 3'd0, 12'h000, 3'd4, 32'h0, "R2 link down read");
    send(1, 8'h03, 8'h02, 5'd0, 3'd0, 12'h004, 3'd4, 32'h22222222, "R2 link down write");
    send(0, 8'h02, 8'h00, 5'd0, 3'd0, 12'h008, 3'd4, 32'h0, "R2 root bus while link down");
    link_up = 1'b1;
    send(0, 8'h02, 8'h00, 5'd0, 3'd0, 12'h008, 3'd3, 32'h0, "R9 size 3 local");
    send(1, 8'h05, 8'h03, 5'd0, 3'd0, 12'h008, 3'd0, 32'h33333333, "R9 size 0 translated write");
    send(0, 8'h02, 8'h00, 5'd2, 3'd0, 12'h008, 3'd3, 32'h0, "R9 R3 no-device wins over bad size");
    lat = 1;
    send(0, 8'h07, 8'h05, 5'd31, 3'd7, 12'h802, 3'd1, 32'h0, "R1 R5 R7 type1 byte read");

    repeat (20) @(negedge clk);
    check(rsp_q.size() == 0 && back_q.size() == 0, "R10", "all expected items consumed",
          rsp_q.size() + back_q.size(), 0);
    check(req_ready, "R10", "ready back high at end", req_ready, 1);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule